// File: doc/BRIEF.md
# Spread Spectrum Fine-Code Dither Generator

This block spreads the output energy of a digitally controlled oscillator over a band of frequencies. It adds a signed offset to the oscillator's 9-bit fine-tuning code, and that offset changes over time. The offset moves only on dither ticks. A tick arrives as a one-cycle enable pulse in the block's clock domain, and that domain is the same one the fine-code dithering uses. The base fine code can come from an open-loop setting or from a closed-loop controller. The block treats the base code the same way in both cases.

Four controls shape the modulation: an amplitude code, a step size, an enable, and a switch that gates each tick with a pseudo-random bit. The modulation pattern depends on the amplitude code:
- An amplitude of 0 flips the least significant bit of the code.
- An amplitude of 1 walks a fixed three-entry cycle.
- Larger amplitudes ramp the offset as a triangle between the negative and positive amplitude.

The modulated code saturates at the ends of its range. Each clamp event is recorded in a sticky flag that software can clear.

Top module: `fine_dither`

## Requirements
- R1: While `enable` was low at the last rising edge, `fine_out` equals `fine_in`. The same edge also resets the following state: the offset to 0, the LSB toggle to 0, the three-entry phase to its first entry, the ramp direction to upward, and the PRBS register to its seed value 1.
- R2: The offset and the LSB toggle change only at an edge where `tick` is high, `enable` is high and the tick is qualified.
- R3: When `prbs_en` is high, a tick is qualified only if bit 0 of the 7-bit PRBS register is 1. When `prbs_en` is low, every tick is qualified. On every tick while enabled, the register {b6..b0} shifts to {b5..b0, b6^b5}, whether or not that tick is qualified. This is the x^7+x^6+1 sequence.
- R4: With `amp` = 0, each qualified tick flips the toggle. `fine_out` then equals `fine_in` with its bit 0 inverted while the toggle is 1.
- R5: With `amp` = 1, successive qualified ticks set the offset to +1, then -1, then 0, and the cycle repeats.
- R6: A `step` value of 0 or 1 moves the offset by 1 per qualified tick. A larger value n moves it by n.
- R7: With `amp` of 2 or more, the offset starts at 0 and first moves up by the step on each qualified tick. A move that would reach or pass +amp (or -amp) stops at that limit, and the direction then reverses.
- R8: `fine_out` is `fine_in` plus the offset, saturated to the range 0..511.
- R9: `range_flag` becomes 1 one edge after a cycle in which the sum falls outside 0..511. It stays 1 until `clr_flag` is sampled high. `clr_flag` wins over a simultaneous set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Dither tick enable, one cycle per tick |
| enable | input | 1 | Modulation enable |
| prbs_en | input | 1 | Gate ticks with the pseudo-random bit |
| amp | input | 4 | Amplitude code |
| step | input | 4 | Step size |
| fine_in | input | 9 | Base fine code (open- or closed-loop) |
| clr_flag | input | 1 | Clears the range flag |
| fine_out | output | 9 | Modulated fine code |
| range_flag | output | 1 | Sticky saturation flag |

## Verification
The bench builds the block with its default widths: a 9-bit code, 4-bit amplitude and step, and a 7-bit PRBS. At these sizes the bench can sweep every amplitude code against every step size, with PRBS gating both off and on. Each run uses a base code near 0, at mid-range, or near 511, so both saturation edges and the ramp turnarounds are exercised. An irregular tick pattern and a mid-run flag clear cover the tick qualification and the sticky-flag priority.

// File: rtl/fine_dither.sv
module fine_dither #(
  parameter int FINE_W = 9,
  parameter int AMP_W  = 4,
  parameter int STEP_W = 4,
  parameter int PRBS_W = 7,
  parameter logic [PRBS_W-1:0] SEED = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enable,
  input  logic              prbs_en,
  input  logic [AMP_W-1:0]  amp,
  input  logic [STEP_W-1:0] step,
  input  logic [FINE_W-1:0] fine_in,
  input  logic              clr_flag,
  output logic [FINE_W-1:0] fine_out,
  output logic              range_flag
);
  localparam int OFF_W = ((AMP_W > STEP_W) ? AMP_W : STEP_W) + 2;
  localparam int SUM_W = FINE_W + OFF_W;
  localparam logic signed [SUM_W-1:0] FMAX = SUM_W'((1 << FINE_W) - 1);

  logic signed [OFF_W-1:0] off, off_nx, amp_s, step_s, up_try, dn_try;
  logic [1:0] idx;
  logic dir_up, dir_nx, tog;
  logic [PRBS_W-1:0] lfsr;
  logic signed [SUM_W-1:0] sum;
  logic lo, hi, used;

  assign used   = tick & enable & (~prbs_en | lfsr[0]);
  assign amp_s  = $signed({{(OFF_W-AMP_W){1'b0}}, amp});
  assign step_s = (step <= STEP_W'(1)) ? OFF_W'(1) : $signed({{(OFF_W-STEP_W){1'b0}}, step});
  assign up_try = off + step_s;
  assign dn_try = off - step_s;

  always_comb begin
    off_nx = off;
    dir_nx = dir_up;
    if (amp == AMP_W'(0)) begin
      off_nx = '0;
    end else if (amp == AMP_W'(1)) begin
      case (idx)
        2'd0:    off_nx = OFF_W'(1);
        2'd1:    off_nx = -OFF_W'(1);
        default: off_nx = '0;
      endcase
    end else if (dir_up) begin
      if (up_try >= amp_s) begin
        off_nx = amp_s;
        dir_nx = 1'b0;
      end else begin
        off_nx = up_try;
      end
    end else begin
      if (dn_try <= -amp_s) begin
        off_nx = -amp_s;
        dir_nx = 1'b1;
      end else begin
        off_nx = dn_try;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off    <= '0;
      idx    <= 2'd0;
      dir_up <= 1'b1;
      tog    <= 1'b0;
      lfsr   <= SEED;
    end else if (!enable) begin
      off    <= '0;
      idx    <= 2'd0;
      dir_up <= 1'b1;
      tog    <= 1'b0;
      lfsr   <= SEED;
    end else if (tick) begin
      lfsr <= {lfsr[PRBS_W-2:0], lfsr[PRBS_W-1] ^ lfsr[PRBS_W-2]};
      if (used) begin
        off    <= off_nx;
        dir_up <= dir_nx;
        if (amp == AMP_W'(0)) tog <= ~tog;
        if (amp == AMP_W'(1)) idx <= (idx == 2'd2) ? 2'd0 : idx + 2'd1;
      end
    end
  end

  assign sum = $signed({{(SUM_W-FINE_W){1'b0}}, fine_in ^ {{(FINE_W-1){1'b0}}, tog}})
             + $signed({{(SUM_W-OFF_W){off[OFF_W-1]}}, off});
  assign lo = sum[SUM_W-1];
  assign hi = !lo && (sum > FMAX);
  assign fine_out = lo ? '0 : hi ? FMAX[FINE_W-1:0] : sum[FINE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          range_flag <= 1'b0;
    else if (clr_flag)   range_flag <= 1'b0;
    else if (lo || hi)   range_flag <= 1'b1;
  end
endmodule

module fine_dither_chk #(
  parameter int FINE_W = 9,
  parameter int OFF_W  = 6,
  parameter int PRBS_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              enable,
  input logic              prbs_en,
  input logic              clr_flag,
  input logic [FINE_W-1:0] fine_in,
  input logic [FINE_W-1:0] fine_out,
  input logic              range_flag,
  input logic [OFF_W-1:0]  off,
  input logic              tog,
  input logic [PRBS_W-1:0] lfsr
);
  a_r1_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (fine_out == fine_in));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tick) |=> ($stable(off) && $stable(tog)));
  a_r3_prbs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick && prbs_en && !lfsr[0]) |=> ($stable(off) && $stable(tog)));
  a_r3_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (range_flag && !clr_flag) |=> range_flag);
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_flag |=> !range_flag);
endmodule

bind fine_dither fine_dither_chk #(.FINE_W(FINE_W), .OFF_W(OFF_W), .PRBS_W(PRBS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable), .prbs_en(prbs_en),
  .clr_flag(clr_flag), .fine_in(fine_in), .fine_out(fine_out),
  .range_flag(range_flag), .off(off), .tog(tog), .lfsr(lfsr));

// File: tb/fine_dither_test.sv
module fine_dither_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, enable = 1'b0, prbs_en = 1'b0, clr_flag = 1'b0;
  logic [3:0] amp = '0, step = '0;
  logic [8:0] fine_in = '0;
  logic [8:0] fine_out;
  logic range_flag;

  fine_dither uut (.clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable),
    .prbs_en(prbs_en), .amp(amp), .step(step), .fine_in(fine_in),
    .clr_flag(clr_flag), .fine_out(fine_out), .range_flag(range_flag));

  always #10 clk = ~clk;

  int vectors = 0, errors = 0;
  bit done = 0;

  int m_off, m_idx;
  bit m_dir, m_tog, m_flag;
  logic [6:0] m_lfsr;

  function automatic int raw_sum(input logic [8:0] f);
    return int'(f ^ {8'd0, m_tog}) + m_off;
  endfunction

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (amp=%0d step=%0d prbs=%0b)",
               req, got, exp, amp, step, prbs_en);
    end
  endtask

  task automatic cycle(input bit en, input bit tk, input bit clr, input logic [8:0] f);
    int s, sz, n, e;
    string tag;
    @(negedge clk);
    enable = en; tick = tk; clr_flag = clr; fine_in = f;
    s = raw_sum(f);
    if (clr) m_flag = 0;
    else if (s < 0 || s > 511) m_flag = 1;
    if (!en) begin
      m_off = 0; m_idx = 0; m_dir = 1; m_tog = 0; m_lfsr = 7'd1;
    end else if (tk) begin
      bit q;
      q = !prbs_en || m_lfsr[0];
      m_lfsr = {m_lfsr[5:0], m_lfsr[6] ^ m_lfsr[5]};
      if (q) begin
        sz = (step <= 1) ? 1 : int'(step);
        if (amp == 0) m_tog = ~m_tog;
        else if (amp == 1) begin
          m_off = (m_idx == 0) ? 1 : (m_idx == 1) ? -1 : 0;
          m_idx = (m_idx + 1) % 3;
        end else if (m_dir) begin
          n = m_off + sz;
          if (n >= int'(amp)) begin m_off = amp; m_dir = 0; end else m_off = n;
        end else begin
          n = m_off - sz;
          if (n <= -int'(amp)) begin m_off = -int'(amp); m_dir = 1; end else m_off = n;
        end
      end
    end
    @(posedge clk); #1;
    s = raw_sum(f);
    e = (s < 0) ? 0 : (s > 511) ? 511 : s;
    if (!en) tag = "R1";
    else if (s < 0 || s > 511) tag = "R8";
    else if (prbs_en) tag = "R3";
    else if (amp == 0) tag = "R4";
    else if (amp == 1) tag = "R5";
    else if (step <= 1) tag = "R6";
    else tag = "R7";
    check(tag, fine_out, 9'(e));
    check("R9", {8'd0, range_flag}, {8'd0, m_flag});
  endtask

  initial begin
    automatic logic [8:0] bases[5] = '{9'd0, 9'd3, 9'd256, 9'd508, 9'd511};
    m_off = 0; m_idx = 0; m_dir = 1; m_tog = 0; m_lfsr = 7'd1; m_flag = 0;
    fine_in = 9'd77;
    #25;
    check("R1", fine_out, 9'd77);
    check("R9", {8'd0, range_flag}, 9'd0);
    rst_n = 1'b1;
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < 16; a++) begin
        for (int st = 0; st < 16; st++) begin
          if (a < 2 && st > 1) continue;
          @(negedge clk);
          prbs_en = p[0]; amp = 4'(a); step = 4'(st);
          cycle(1'b0, 1'b1, 1'b0, bases[(a + st + p) % 5]);
          cycle(1'b0, 1'b0, 1'b1, 9'(a * 31 + st));
          for (int c = 0; c < 30; c++)
            cycle(1'b1, (c % 3) != 2, c == 20, bases[(a + st + p) % 5]);
        end
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(20ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule